// File: doc/BRIEF.md
# Smart Card Activation Command Controller

This block is the host-side control logic of a smart card reader front end. The host requests a card session by pulling one or both of two active-low command inputs. The block decodes those inputs into a card supply selection. A single command selects 5V or 3V. When the two commands fall close together, the selection is 1.8V. The block then powers the card up in a fixed order, and powers it down in the reverse order when the host releases both commands or when a fault appears.

A single active-low `off_n` line serves as the host interrupt. With no session running, it shows whether a card is inserted. Once the host has asserted a command, it reports a fault instead. The fault sources are card removal, a card supply fault, an over-current fault and a digital-supply fault. Any of them tears the session down without host action. The fault stays latched until the host releases both commands.

The block also gates the host reset onto the card reset line, and divides the block clock into the card clock at one of four ratios. A new ratio is applied only at a low phase, so the card clock never shows a shortened pulse.

Top module: `sc_act_ctrl`

## Requirements
- R1: `vsel` reports the supply of the running session as 2'b01 for 5V (only `cmd5_n` low), 2'b10 for 3V (only `cmd3_n` low) and 2'b11 for 1.8V. It reads 2'b00 whenever `vcc_en` is low.
- R2: If the second command input is sampled low no more than WIN_CYC = WINDOW_NS/CLK_PERIOD_NS clock edges after the first, the session is 1.8V. A single command starts activation once WIN_CYC edges have passed. Two commands falling on the same edge start activation at once.
- R3: A second command that falls later than the window is ignored, and the first voltage is kept. The session ends only when both commands are high.
- R4: Activation raises `vcc_en` first and `io_en` STEP_CYCLES edges later. The card clock starts after 2·STEP_CYCLES edges; with ratio select 0, its first rise comes 2·STEP_CYCLES+1 edges after `vcc_en`. The card reset is enabled 3·STEP_CYCLES edges after `vcc_en`.
- R5: While idle, `off_n` equals `card_present`, so it is low when no card is inserted.
- R6: During a session, a fault sampled at an edge drives `off_n` low after that edge. It starts deactivation, and `off_n` stays low until both commands are high.
- R7: `vdd_fault` ends a session in the same way as a card fault. While idle, it has no effect on `off_n` or the supply.
- R8: `card_rst` equals `host_rst` only while the card reset is enabled by the sequence. Otherwise it is low.
- R9: Each card clock phase, high or low, lasts 1, 2, 4 or 8 clock cycles for `div_sel` = 0, 1, 2 or 3.
- R10: A change of `div_sel` takes effect at the next falling edge of the card clock. A high phase that is already running keeps its full old length.
- R11: Deactivation drops the card reset one edge after its cause. The card clock stops low while `io_en` is still high. `io_en` falls 2·STEP_CYCLES+1 edges after the cause, and `vcc_en` falls 3·STEP_CYCLES+1 edges after it. STEP_CYCLES must be at least 9.
- R12: Releasing both commands with no fault deactivates in the same order, and `off_n` never goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the card clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd5_n | input | 1 | Active-low 5V activation command |
| cmd3_n | input | 1 | Active-low 3V activation command |
| host_rst | input | 1 | Host-driven card reset level |
| div_sel | input | 2 | Card clock ratio select |
| card_present | input | 1 | High while a card is inserted |
| vcc_fault | input | 1 | Card supply out of range |
| ovc_fault | input | 1 | Card supply over-current |
| vdd_fault | input | 1 | Digital supply below threshold |
| off_n | output | 1 | Active-low presence/fault interrupt |
| vsel | output | 2 | Selected card supply code |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O enable |
| card_clk | output | 1 | Divided card clock |
| card_rst | output | 1 | Card reset line |

## Verification
The bench sweeps the gap between the two command falls across the window edge, in both orders. A design that is off by one in its window counter picks 1.8V one cycle too late, or keeps a single voltage one cycle too early. It also measures every card clock phase at all four ratios. It switches the ratio in the middle of a long high phase, where a design that reloads at once would cut that pulse short. The power-up and power-down edges are timed against the fault cycle, so a reordered or mistimed step moves a stamp. The bench also holds the commands low after a fault and checks that `off_n` stays latched. A design that clears the fault when the supply turns off would let `off_n` rise too early.

// File: rtl/sc_act_ctrl.sv
module sc_act_ctrl #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int WINDOW_NS     = 400,
  parameter int STEP_CYCLES   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd5_n,
  input  logic       cmd3_n,
  input  logic       host_rst,
  input  logic [1:0] div_sel,
  input  logic       card_present,
  input  logic       vcc_fault,
  input  logic       ovc_fault,
  input  logic       vdd_fault,
  output logic       off_n,
  output logic [1:0] vsel,
  output logic       vcc_en,
  output logic       io_en,
  output logic       card_clk,
  output logic       card_rst
);
  localparam int WIN_CYC = WINDOW_NS / CLK_PERIOD_NS;
  localparam int WCW     = $clog2(WIN_CYC + 1);
  localparam int SW      = $clog2(STEP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_UP, S_ON, S_DOWN, S_LOCK} st_t;

  st_t            st;
  logic [2:0]     lvl;
  logic [SW-1:0]  tmr;
  logic [WCW-1:0] wcnt;
  logic [1:0]     vreg;
  logic           flt;

  wire c5      = ~cmd5_n;
  wire c3      = ~cmd3_n;
  wire any_cmd = c5 | c3;
  wire both    = c5 & c3;
  wire fault   = ~card_present | vcc_fault | ovc_fault | vdd_fault;
  wire session = (st == S_UP) || (st == S_ON);
  wire clk_en  = lvl >= 3'd3;
  wire rst_en  = lvl == 3'd4;

  assign vcc_en   = lvl != 3'd0;
  assign io_en    = lvl >= 3'd2;
  assign vsel     = vcc_en ? vreg : 2'b00;
  assign off_n    = (st == S_IDLE) ? card_present : ~flt;
  assign card_rst = host_rst & rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lvl  <= '0;
      tmr  <= '0;
      wcnt <= '0;
      vreg <= 2'b00;
      flt  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          flt <= 1'b0;
          if (both) begin
            vreg <= 2'b11;
            lvl  <= 3'd1;
            tmr  <= SW'(STEP_CYCLES - 1);
            st   <= S_UP;
          end else if (any_cmd) begin
            vreg <= c5 ? 2'b01 : 2'b10;
            wcnt <= '0;
            st   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (!any_cmd) st <= S_IDLE;
          else if (both || wcnt == WCW'(WIN_CYC - 1)) begin
            if (both) vreg <= 2'b11;
            lvl <= 3'd1;
            tmr <= SW'(STEP_CYCLES - 1);
            st  <= S_UP;
          end else wcnt <= wcnt + 1'b1;
        end
        S_UP, S_ON: begin
          if (fault || !any_cmd) begin
            flt <= fault;
            tmr <= '0;
            st  <= S_DOWN;
          end else if (st == S_UP) begin
            if (tmr == '0) begin
              lvl <= lvl + 3'd1;
              tmr <= SW'(STEP_CYCLES - 1);
              if (lvl == 3'd3) st <= S_ON;
            end else tmr <= tmr - 1'b1;
          end
        end
        S_DOWN: begin
          if (tmr == '0) begin
            if (lvl == 3'd0) st <= any_cmd ? S_LOCK : S_IDLE;
            else begin
              lvl <= lvl - 3'd1;
              tmr <= SW'(STEP_CYCLES - 1);
            end
          end else tmr <= tmr - 1'b1;
        end
        S_LOCK:  if (!any_cmd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic [2:0] half_m1(input logic [1:0] s);
    return 3'((4'd1 << s) - 4'd1);
  endfunction

  logic [1:0] cur_sel;
  logic [2:0] hc;
  logic       ck;
  wire        run = clk_en | ck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck      <= 1'b0;
      cur_sel <= 2'b00;
      hc      <= 3'd0;
    end else if (!run) begin
      ck      <= 1'b0;
      cur_sel <= div_sel;
      hc      <= half_m1(div_sel);
    end else if (hc == 3'd0) begin
      ck <= ~ck;
      if (ck) begin
        cur_sel <= div_sel;
        hc      <= half_m1(div_sel);
      end else hc <= half_m1(cur_sel);
    end else hc <= hc - 3'd1;
  end

  assign card_clk = ck;

  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rst_n) card_clk |-> io_en); // R11
  AST_OFF_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (session && fault) |=> !off_n); // R6
  AST_LATE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_ON && any_cmd && !fault) |=> $stable(vsel)); // R3
  AST_DOWN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) (st == S_DOWN) |=> !$rose(vcc_en)); // R11
  AST_WAIT_NO_VCC: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAIT) |-> !vcc_en); // R2
endmodule

// File: tb/sim_sc_act_ctrl.sv
module sim_sc_act_ctrl;
  localparam int PER = 5;
  localparam int WIN_NS = 40;
  localparam int S = 10;
  localparam int WIN = WIN_NS / PER;

  logic clk = 0, rst_n = 0;
  logic cmd5_n = 1, cmd3_n = 1, host_rst = 1, card_present = 1;
  logic vcc_fault = 0, ovc_fault = 0, vdd_fault = 0;
  logic [1:0] div_sel = 0;
  logic off_n, vcc_en, io_en, card_clk, card_rst;
  logic [1:0] vsel;

  sc_act_ctrl #(.CLK_PERIOD_NS(PER), .WINDOW_NS(WIN_NS), .STEP_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd5_n(cmd5_n), .cmd3_n(cmd3_n), .host_rst(host_rst),
    .div_sel(div_sel), .card_present(card_present), .vcc_fault(vcc_fault),
    .ovc_fault(ovc_fault), .vdd_fault(vdd_fault), .off_n(off_n), .vsel(vsel),
    .vcc_en(vcc_en), .io_en(io_en), .card_clk(card_clk), .card_rst(card_rst));

  always #(PER / 2.0) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 0;
  int t_vcc_r = -1, t_vcc_f = -1, t_io_r = -1, t_io_f = -1;
  int t_clk_r = -1, t_clk_f = -1, t_clk_first = -1, t_rst_r = -1, t_rst_f = -1, t_off_f = -1;
  int hi_len = 0, lo_len = 0;
  logic p_vcc = 0, p_io = 0, p_clk = 0, p_rst = 0, p_off = 1;

  always @(negedge clk) begin
    if (vcc_en && !p_vcc) t_vcc_r = cyc;
    if (!vcc_en && p_vcc) t_vcc_f = cyc;
    if (io_en && !p_io) t_io_r = cyc;
    if (!io_en && p_io) t_io_f = cyc;
    if (card_clk && !p_clk) begin
      if (t_clk_r >= 0 || t_clk_f >= 0) lo_len = cyc - t_clk_f;
      t_clk_r = cyc;
      if (t_clk_first < 0) t_clk_first = cyc;
    end
    if (!card_clk && p_clk) begin hi_len = cyc - t_clk_r; t_clk_f = cyc; end
    if (card_rst && !p_rst) t_rst_r = cyc;
    if (!card_rst && p_rst) t_rst_f = cyc;
    if (!off_n && p_off) t_off_f = cyc;
    p_vcc = vcc_en; p_io = io_en; p_clk = card_clk; p_rst = card_rst; p_off = off_n;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_vcc();
    for (int i = 0; i < 200 && !vcc_en; i++) tick(1);
  endtask

  task automatic release_all();
    cmd5_n = 1; cmd3_n = 1;
    tick(4 * S + 10);
  endtask

  task automatic activate(input logic a5, input logic a3);
    cmd5_n = a5; cmd3_n = a3;
    tick(WIN + 3 * S + 10);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    // reset state
    chk("R1 reset vsel", vsel, 0);
    chk("R4 reset vcc_en", vcc_en, 0);
    chk("R8 reset card_rst", card_rst, 0);
    chk("R9 reset card_clk", card_clk, 0);
    // R5 presence mirror while idle
    card_present = 0; tick(1);
    chk("R5 no card", off_n, 0);
    card_present = 1; tick(1);
    chk("R5 card in", off_n, 1);
    // R7 vdd fault while idle has no effect
    vdd_fault = 1; tick(3);
    chk("R7 idle off_n", off_n, 1);
    chk("R7 idle vcc", vcc_en, 0);
    vdd_fault = 0; tick(1);

    // R2 window sweep, both orders
    for (int ord = 0; ord < 2; ord++) begin
      for (int k = 0; k <= WIN + 4; k++) begin
        int exp;
        if (ord == 0) cmd5_n = 0; else cmd3_n = 0;
        if (k == 0) begin cmd5_n = 0; cmd3_n = 0; end
        else begin tick(k); cmd5_n = 0; cmd3_n = 0; end
        wait_vcc();
        exp = (k <= WIN) ? 3 : (ord == 0 ? 1 : 2);
        chk(k <= WIN ? "R2 window 1.8V" : "R3 late edge kept", vsel, exp);
        release_all();
      end
    end

    // R1 single commands
    activate(0, 1);
    chk("R1 5V", vsel, 1);
    release_all();
    activate(1, 0);
    chk("R1 3V", vsel, 2);
    // R3 late second edge, then release of the first only
    tick(5); cmd5_n = 0; tick(20);
    chk("R3 late edge vsel", vsel, 2);
    cmd3_n = 1; tick(3 * S);
    chk("R3 one cmd held vcc", vcc_en, 1);
    chk("R3 one cmd held vsel", vsel, 2);
    release_all();
    chk("R3 both released", vcc_en, 0);

    // R4 activation order
    div_sel = 0; host_rst = 1;
    t_clk_first = -1;
    activate(0, 1);
    chk("R4 io after vcc", t_io_r - t_vcc_r, S);
    chk("R4 clk start", t_clk_first - t_vcc_r, 2 * S + 1);
    chk("R4 rst after vcc", t_rst_r - t_vcc_r, 3 * S);

    // R8 reset gating
    host_rst = 0; tick(1);
    chk("R8 follow low", card_rst, 0);
    host_rst = 1; tick(1);
    chk("R8 follow high", card_rst, 1);

    // R9 every ratio
    for (int s = 0; s < 4; s++) begin
      div_sel = 2'(s); tick(40);
      chk("R9 high phase", hi_len, 1 << s);
      chk("R9 low phase", lo_len, 1 << s);
    end
    // R10 change during a long high phase
    div_sel = 3; tick(20);
    for (int i = 0; i < 40 && !card_clk; i++) tick(1);
    tick(2); div_sel = 0;
    for (int i = 0; i < 40 && card_clk; i++) tick(1);
    tick(1);
    chk("R10 high kept", hi_len, 8);
    for (int i = 0; i < 40 && !card_clk; i++) tick(1);
    tick(1);
    chk("R10 new low", lo_len, 1);

    // R6/R11 fault deactivation with commands held
    begin
      int f;
      div_sel = 0; tick(5);
      f = cyc + 1;
      vcc_fault = 1; tick(1); vcc_fault = 0;
      tick(4 * S + 5);
      chk("R6 off_n fall", t_off_f - f, 0);
      chk("R11 rst drop", t_rst_f - f, 1);
      chk("R11 io drop", t_io_f - f, 2 * S + 1);
      chk("R11 vcc drop", t_vcc_f - f, 3 * S + 1);
      chk("R11 clk stop after rst", int'(t_clk_f > t_rst_f), 1);
      chk("R11 clk stop before io", int'(t_clk_f < t_io_f), 1);
      chk("R11 clk low", card_clk, 0);
      chk("R6 latched", off_n, 0);
      cmd5_n = 1; tick(3);
      chk("R6 cleared", off_n, 1);
    end

    // R7 vdd fault during session
    activate(1, 0);
    vdd_fault = 1; tick(1); vdd_fault = 0;
    chk("R7 off_n", off_n, 0);
    tick(4 * S + 5);
    chk("R7 supply off", vcc_en, 0);
    cmd3_n = 1; tick(3);

    // card removal during session
    activate(0, 1);
    card_present = 0; tick(1);
    chk("R6 removal off_n", off_n, 0);
    card_present = 1; tick(4 * S + 5);
    chk("R6 removal vcc", vcc_en, 0);
    cmd5_n = 1; tick(3);

    // R12 normal release
    begin
      int off_prev;
      activate(0, 0);
      off_prev = t_off_f;
      release_all();
      chk("R12 off_n never low", t_off_f, off_prev);
      chk("R12 supply off", vcc_en, 0);
      chk("R12 order", int'(t_rst_f < t_io_f && t_io_f < t_vcc_f), 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule